// File: doc/BRIEF.md
# In-band Xon/Xoff Flow Controller

This block handles software flow control for a serial port. It watches every character the receiver delivers and compares it with four programmable codes: two resume codes and two stop codes. A stop match holds the local transmitter paused. A resume match releases it. Depending on the selected mode, a match is either one character or a pair of characters that arrive back to back. An optional "resume on anything" setting lets any received character release a paused transmitter.

In the other direction, the block watches the fill level of the local receive buffer. When the level rises to a trigger point, it asks the transmitter to send a stop code once. When the buffer later drains to a release point, it asks for a resume code once. Characters go to the transmitter through a request/acknowledge handshake, one character per acknowledge. When a received character completes a match, the block flags it in the same cycle, so the receive path can keep it out of the buffer.

Top module: `xonxoff_flow_ctrl`

## Requirements
- R1: `fc_mode[1:0]` selects recognition. 00 is off. 01 matches single characters against `xon_char1`/`xoff_char1`. 10 matches single characters against `xon_char2`/`xoff_char2`. 11 matches two-character sequences: char1 followed by char2.
- R2: In a single-character mode, a received stop code sets `tx_pause` at the clock edge that samples it. A received resume code clears `tx_pause` at that edge. If both codes are equal, the stop code wins.
- R3: In sequence mode, `xoff_char1` followed immediately by `xoff_char2` sets `tx_pause`. `xon_char1` followed immediately by `xon_char2` clears it.
- R4: In sequence mode, any other character arriving after a first code abandons the partial match. A character equal to a first code starts a new partial match, even if it interrupted another one.
- R5: With `xon_any` high and recognition on, any received character that does not complete a stop match clears `tx_pause`.
- R6: `rx_consumed` is combinational and valid while `rx_valid` is high. It is 1 only for the character that completes a resume or stop match; in sequence mode that is only the second code. It stays 0 for a data character that releases the pause through `xon_any`.
- R7: On reset, and in any cycle where `fc_mode[1:0]` is 00, the next edge clears `tx_pause` and discards any partial match. While recognition is off, `rx_consumed` stays 0.
- R8: `fc_mode[3:2]` selects insertion. 00 is off. 01 sends the char1 code. 10 sends the char2 code. 11 sends char1 followed by char2.
- R9: When `rx_level >= rx_trig` and no stop code is outstanding, one stop request starts on the next edge. No further stop request starts until a resume code has been requested.
- R10: When a stop code is outstanding and `rx_level <= rx_release`, one resume request starts on the next edge.
- R11: `ins_req` and `ins_data` hold steady until `ins_ack` is sampled high. Each acknowledge consumes exactly one character.
- R12: When `fc_mode[3:2]` is 00, the next edge drops `ins_req` and forgets the outstanding stop code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_valid | input | 1 | A received character is present this cycle |
| rx_data | input | CW | The received character |
| xon_char1 | input | CW | First resume code |
| xon_char2 | input | CW | Second resume code |
| xoff_char1 | input | CW | First stop code |
| xoff_char2 | input | CW | Second stop code |
| fc_mode | input | 4 | [1:0] recognition select, [3:2] insertion select |
| xon_any | input | 1 | Any received character releases the pause |
| rx_level | input | LW | Current receive buffer fill |
| rx_trig | input | LW | Fill at or above which a stop code is sent |
| rx_release | input | LW | Fill at or below which a resume code is sent |
| ins_ack | input | 1 | Transmitter takes the offered character |
| tx_pause | output | 1 | Hold off the local transmitter |
| rx_consumed | output | 1 | Current received character completes a match |
| ins_req | output | 1 | A flow-control character is offered |
| ins_data | output | CW | The offered character |

## Verification
The bench uses a small alphabet made mostly of the four codes, so random streams interleave partial sequences. A matcher that failed to restart on an interrupting first code would miss the resume in "stop1, resume1, resume2". A matcher that leaked state across a disable would pause on a lone second code. The bench checks that a data character releasing the pause under `xon_any` is not flagged as consumed, because a design that flagged it would silently drop user data. On the insertion side, the bench holds the fill above the trigger for many cycles to catch repeated stop requests. It stalls the acknowledge to catch a changing offer, and it disables insertion mid-request to check that the request drops and the stop state is forgotten.

// File: rtl/xfc_pkg.sv
// Shared types for the Xon/Xoff flow controller.
// Assumes a two-bit select encoding shared by recognition and insertion.
package xfc_pkg;
    typedef enum logic [1:0] {
        SEL_OFF    = 2'b00,
        SEL_FIRST  = 2'b01,
        SEL_SECOND = 2'b10,
        SEL_PAIR   = 2'b11
    } fc_sel_e;

    typedef enum logic [1:0] {
        M_IDLE = 2'b00,
        M_ON1  = 2'b01,
        M_OFF1 = 2'b10
    } match_st_e;

    typedef enum logic {
        I_IDLE = 1'b0,
        I_SEND = 1'b1
    } ins_st_e;

    // Index order of the code bank
    localparam int K_ON1  = 0;
    localparam int K_ON2  = 1;
    localparam int K_OFF1 = 2;
    localparam int K_OFF2 = 3;
    localparam int NKEYS  = 4;
endpackage

// File: rtl/xfc_rx_match.sv
// Receive-side recognizer: compares each received character with the code
// bank and keeps the transmit pause flag.
// Assumes rx_valid marks exactly one character per cycle.
module xfc_rx_match
    import xfc_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rx_valid,
    input  logic [CW-1:0]            rx_data,
    input  logic [NKEYS-1:0][CW-1:0] keys,
    input  fc_sel_e                  rsel,
    input  logic                     xon_any,
    output logic                     pause,
    output logic                     consumed
);
    logic [NKEYS-1:0] eq;
    match_st_e        st, st_nxt;
    logic             hit_off, hit_on, release_c;
    logic [CW-1:0]    on_key, off_key;

    // One comparator per programmed code
    for (genvar k = 0; k < NKEYS; k++) begin : g_cmp
        assign eq[k] = (rx_data == keys[k]);
    end

    // Pick the code pair used by the single-character modes
    always_comb begin
        on_key  = (rsel == SEL_SECOND) ? keys[K_ON2]  : keys[K_ON1];
        off_key = (rsel == SEL_SECOND) ? keys[K_OFF2] : keys[K_OFF1];
    end

    // Match decision and next sequence state
    always_comb begin
        hit_off = 1'b0;
        hit_on  = 1'b0;
        st_nxt  = M_IDLE;
        case (rsel)
            SEL_FIRST, SEL_SECOND: begin
                hit_off = rx_valid && (rx_data == off_key);
                hit_on  = rx_valid && !hit_off && (rx_data == on_key);
            end
            SEL_PAIR: begin
                st_nxt = st;
                if (rx_valid) begin
                    hit_off = (st == M_OFF1) && eq[K_OFF2];
                    hit_on  = (st == M_ON1)  && eq[K_ON2];
                    if (hit_off || hit_on) st_nxt = M_IDLE;
                    else if (eq[K_OFF1])   st_nxt = M_OFF1;
                    else if (eq[K_ON1])    st_nxt = M_ON1;
                    else                   st_nxt = M_IDLE;
                end
            end
            default: st_nxt = M_IDLE;
        endcase
    end

    // Release by a resume match or, optionally, by any non-stop character
    always_comb begin
        release_c = hit_on || (xon_any && rx_valid && !hit_off && (rsel != SEL_OFF));
        consumed  = hit_off || hit_on;
    end

    // Sequence state and pause flag; cleared when recognition is off
    always_ff @(posedge clk) begin
        if (!rst_n || rsel == SEL_OFF) begin
            st    <= M_IDLE;
            pause <= 1'b0;
        end else begin
            st <= st_nxt;
            if (hit_off)        pause <= 1'b1;
            else if (release_c) pause <= 1'b0;
        end
    end
endmodule

// File: rtl/xfc_tx_insert.sv
// Transmit-side sequencer: watches the receive buffer fill and offers stop
// or resume codes to the transmitter, one character per acknowledge.
// Assumes rx_release is below rx_trig.
module xfc_tx_insert
    import xfc_pkg::*;
#(
    parameter int CW = 8,
    parameter int LW = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  fc_sel_e                  tsel,
    input  logic [NKEYS-1:0][CW-1:0] keys,
    input  logic [LW-1:0]            rx_level,
    input  logic [LW-1:0]            rx_trig,
    input  logic [LW-1:0]            rx_release,
    input  logic                     ins_ack,
    output logic                     ins_req,
    output logic [CW-1:0]            ins_data
);
    ins_st_e st;
    logic    off_sent;     // a stop code is outstanding at the far end
    logic    kind_off;     // current request is a stop code
    logic    second_due;   // second code of a pair still to go
    logic    want_off, want_on;

    // Threshold crossings that start a new request
    always_comb begin
        want_off = !off_sent && (rx_level >= rx_trig);
        want_on  =  off_sent && (rx_level <= rx_release);
    end

    // Request sequencer with latched data
    always_ff @(posedge clk) begin
        if (!rst_n || tsel == SEL_OFF) begin
            st         <= I_IDLE;
            off_sent   <= 1'b0;
            kind_off   <= 1'b0;
            second_due <= 1'b0;
            ins_data   <= '0;
        end else begin
            case (st)
                I_IDLE: begin
                    if (want_off || want_on) begin
                        st         <= I_SEND;
                        off_sent   <= want_off;
                        kind_off   <= want_off;
                        second_due <= (tsel == SEL_PAIR);
                        if (want_off)
                            ins_data <= (tsel == SEL_SECOND) ? keys[K_OFF2] : keys[K_OFF1];
                        else
                            ins_data <= (tsel == SEL_SECOND) ? keys[K_ON2] : keys[K_ON1];
                    end
                end
                default: begin
                    if (ins_ack) begin
                        if (second_due) begin
                            second_due <= 1'b0;
                            ins_data   <= kind_off ? keys[K_OFF2] : keys[K_ON2];
                        end else begin
                            st <= I_IDLE;
                        end
                    end
                end
            endcase
        end
    end

    // Offer is visible whenever a character is pending
    assign ins_req = (st == I_SEND);
endmodule

// File: rtl/xonxoff_flow_ctrl.sv
// Top of the Xon/Xoff flow controller: packs the code bank, splits the mode
// field and joins the receive recognizer with the insertion sequencer.
// Assumes a single clock domain and synchronous active-low reset.
module xonxoff_flow_ctrl
    import xfc_pkg::*;
#(
    parameter int CW = 8,
    parameter int LW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic [CW-1:0] rx_data,
    input  logic [CW-1:0] xon_char1,
    input  logic [CW-1:0] xon_char2,
    input  logic [CW-1:0] xoff_char1,
    input  logic [CW-1:0] xoff_char2,
    input  logic [3:0]    fc_mode,
    input  logic          xon_any,
    input  logic [LW-1:0] rx_level,
    input  logic [LW-1:0] rx_trig,
    input  logic [LW-1:0] rx_release,
    input  logic          ins_ack,
    output logic          tx_pause,
    output logic          rx_consumed,
    output logic          ins_req,
    output logic [CW-1:0] ins_data
);
    logic [NKEYS-1:0][CW-1:0] keys;
    fc_sel_e                  rsel, tsel;

    // Code bank and select fields
    always_comb begin
        keys[K_ON1]  = xon_char1;
        keys[K_ON2]  = xon_char2;
        keys[K_OFF1] = xoff_char1;
        keys[K_OFF2] = xoff_char2;
        rsel = fc_sel_e'(fc_mode[1:0]);
        tsel = fc_sel_e'(fc_mode[3:2]);
    end

    xfc_rx_match #(.CW(CW)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .keys     (keys),
        .rsel     (rsel),
        .xon_any  (xon_any),
        .pause    (tx_pause),
        .consumed (rx_consumed)
    );

    xfc_tx_insert #(.CW(CW), .LW(LW)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .tsel       (tsel),
        .keys       (keys),
        .rx_level   (rx_level),
        .rx_trig    (rx_trig),
        .rx_release (rx_release),
        .ins_ack    (ins_ack),
        .ins_req    (ins_req),
        .ins_data   (ins_data)
    );
endmodule

// File: rtl/xfc_checker.sv
// Property checker for the flow controller, bound to the top module.
module xfc_checker #(
    parameter int CW = 8,
    parameter int LW = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_valid,
    input logic [CW-1:0] rx_data,
    input logic [CW-1:0] xoff_char1,
    input logic [3:0]    fc_mode,
    input logic          ins_ack,
    input logic          tx_pause,
    input logic          rx_consumed,
    input logic          ins_req,
    input logic [CW-1:0] ins_data
);
    AST_XOFF_PAUSES: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && fc_mode[1:0] == 2'b01 && rx_data == xoff_char1 |=> tx_pause); // R2
    AST_PAUSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tx_pause) |-> $past(rx_valid) || $past(fc_mode[1:0]) == 2'b00); // R3
    AST_CONS_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        rx_consumed |-> rx_valid && fc_mode[1:0] != 2'b00); // R6
    AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        fc_mode[1:0] == 2'b00 |=> !tx_pause); // R7
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ins_req && !ins_ack && fc_mode[3:2] != 2'b00 |=> ins_req && $stable(ins_data)); // R11
    AST_INS_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        fc_mode[3:2] == 2'b00 |=> !ins_req); // R12
endmodule

bind xonxoff_flow_ctrl xfc_checker #(.CW(CW), .LW(LW)) u_chk (.*);

// File: tb/sim_xonxoff_flow_ctrl.sv
module sim_xonxoff_flow_ctrl;
    localparam int CW = 8;
    localparam int LW = 7;
    localparam logic [7:0] ON1 = 8'h11, ON2 = 8'h12, OFF1 = 8'h13, OFF2 = 8'h14;

    logic clk = 1'b0, rst_n = 1'b0;
    logic rx_valid = 1'b0, xon_any = 1'b0, ins_ack = 1'b0;
    logic [CW-1:0] rx_data = '0;
    logic [3:0] fc_mode = 4'b0000;
    logic [LW-1:0] rx_level = '0, rx_trig = 7'd48, rx_release = 7'd16;
    logic tx_pause, rx_consumed, ins_req;
    logic [CW-1:0] ins_data;

    int checks = 0, fails = 0, cyc = 0;
    bit m_pause = 0, m_cons = 0;
    int m_st = 0;              // 0 idle, 1 after resume1, 2 after stop1

    always #5 clk = ~clk;

    xonxoff_flow_ctrl #(.CW(CW), .LW(LW)) u0 (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .xon_char1(ON1), .xon_char2(ON2), .xoff_char1(OFF1), .xoff_char2(OFF2),
        .fc_mode(fc_mode), .xon_any(xon_any), .rx_level(rx_level),
        .rx_trig(rx_trig), .rx_release(rx_release), .ins_ack(ins_ack),
        .tx_pause(tx_pause), .rx_consumed(rx_consumed),
        .ins_req(ins_req), .ins_data(ins_data));

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            fails = fails + 1;
            $display("FAIL watchdog: act=%0d exp<=100000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // Reference model of recognition, from R1..R6
    task automatic model_rx(input logic [7:0] c);
        bit hoff = 0, hon = 0;
        int rm = int'(fc_mode[1:0]);
        if (rm == 1) begin hoff = (c == OFF1); hon = !hoff && (c == ON1); m_st = 0; end
        else if (rm == 2) begin hoff = (c == OFF2); hon = !hoff && (c == ON2); m_st = 0; end
        else if (rm == 3) begin
            hoff = (m_st == 2) && (c == OFF2);
            hon  = (m_st == 1) && (c == ON2);
            if (hoff || hon) m_st = 0;
            else if (c == OFF1) m_st = 2;
            else if (c == ON1) m_st = 1;
            else m_st = 0;
        end
        m_cons = hoff || hon;
        if (rm != 0) begin
            if (hoff) m_pause = 1;
            else if (hon || xon_any) m_pause = 0;
        end
    endtask

    task automatic send_char(input logic [7:0] c, input string req);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = c;
        model_rx(c);
        #1 chk(rx_consumed == m_cons, {req, " consumed"}, rx_consumed, m_cons);
        @(negedge clk);
        rx_valid = 1'b0;
        #1 chk(tx_pause == m_pause, {req, " pause"}, tx_pause, m_pause);
    endtask

    // Pass through recognition-off to change mode (R7)
    task automatic set_rmode(input logic [1:0] m);
        @(negedge clk); fc_mode[1:0] = 2'b00;
        @(negedge clk); m_pause = 0; m_st = 0;
        #1 chk(tx_pause == 1'b0, "R7 off clears", tx_pause, 0);
        fc_mode[1:0] = m;
    endtask

    task automatic expect_req(input bit r, input logic [7:0] d, input string req);
        #1 chk(ins_req == r, {req, " req"}, ins_req, r);
        if (r) chk(ins_data == d, {req, " data"}, ins_data, d);
    endtask

    task automatic ack_one;
        @(negedge clk); ins_ack = 1'b1;
        @(negedge clk); ins_ack = 1'b0;
    endtask

    initial begin
        void'($urandom(32'h5eed));
        repeat (3) @(negedge clk);
        #1 chk(tx_pause == 0 && ins_req == 0 && rx_consumed == 0, "R7 reset", tx_pause, 0);
        rst_n = 1'b1;

        // R1 R2: single mode, first bank
        set_rmode(2'b01);
        send_char(OFF1, "R2 stop1");
        send_char(8'h41, "R2 data while paused");
        send_char(ON1, "R2 resume1");
        send_char(OFF2, "R1 other bank ignored");
        // R1: second bank
        set_rmode(2'b10);
        send_char(OFF2, "R1 stop2");
        send_char(ON2, "R1 resume2");
        // R3 R4: sequence mode
        set_rmode(2'b11);
        send_char(OFF1, "R3 stop first half");
        send_char(OFF2, "R3 stop pair");
        send_char(ON1, "R4 resume first");
        send_char(8'h41, "R4 interrupt");
        send_char(ON2, "R4 lone second");
        send_char(OFF1, "R4 stop1 then");
        send_char(ON1, "R4 restart by resume1");
        send_char(ON2, "R4 resume pair");
        // R5 R6: any-char release
        send_char(OFF1, "R5 setup"); send_char(OFF2, "R5 pause");
        xon_any = 1'b1;
        send_char(8'h42, "R5 R6 any releases, not consumed");
        xon_any = 1'b0;
        // R7: disable mid sequence discards partial match
        send_char(OFF1, "R7 partial");
        set_rmode(2'b11);
        send_char(OFF2, "R7 partial discarded");
        @(negedge clk); fc_mode[1:0] = 2'b00; rx_valid = 1'b1; rx_data = OFF1;
        #1 chk(rx_consumed == 0, "R7 no consume when off", rx_consumed, 0);
        @(negedge clk); rx_valid = 1'b0;

        // Random streams over a small alphabet
        for (int blk = 0; blk < 8; blk++) begin
            set_rmode(2'(1 + $urandom_range(0, 2)));
            xon_any = 1'($urandom_range(0, 3) == 0);
            for (int n = 0; n < 40; n++) begin
                logic [7:0] pick [6];
                pick = '{ON1, ON2, OFF1, OFF2, 8'h41, 8'h13 ^ 8'h80};
                send_char(pick[$urandom_range(0, 5)], "R3 R5 random");
            end
        end
        xon_any = 1'b0;
        set_rmode(2'b00);

        // R8..R12: insertion
        rx_level = 7'd10;
        @(negedge clk); fc_mode[3:2] = 2'b11;
        @(negedge clk); expect_req(0, 0, "R9 below trig");
        rx_level = 7'd48;
        @(negedge clk); expect_req(1, OFF1, "R9 R8 stop first");
        repeat (3) begin @(negedge clk); expect_req(1, OFF1, "R11 hold without ack"); end
        ack_one; expect_req(1, OFF2, "R8 R11 stop second");
        ack_one; expect_req(0, 0, "R11 done");
        rx_level = 7'd60;
        repeat (5) @(negedge clk);
        expect_req(0, 0, "R9 only once");
        rx_level = 7'd30;
        @(negedge clk); expect_req(0, 0, "R10 between thresholds");
        rx_level = 7'd16;
        @(negedge clk); expect_req(1, ON1, "R10 resume first");
        ack_one; expect_req(1, ON2, "R10 resume second");
        ack_one; expect_req(0, 0, "R10 done once");
        fc_mode[3:2] = 2'b01; rx_level = 7'd50;
        @(negedge clk); expect_req(1, OFF1, "R8 single first bank");
        ack_one; expect_req(0, 0, "R8 single one char");
        rx_level = 7'd5;
        @(negedge clk); expect_req(1, ON1, "R8 single resume");
        ack_one; expect_req(0, 0, "R8 single resume done");
        fc_mode[3:2] = 2'b10; rx_level = 7'd50;
        @(negedge clk); expect_req(1, OFF2, "R8 second bank");
        fc_mode[3:2] = 2'b00;
        @(negedge clk); expect_req(0, 0, "R12 disable drops");
        fc_mode[3:2] = 2'b10;
        @(negedge clk); expect_req(1, OFF2, "R12 stop state forgotten");
        ack_one; expect_req(0, 0, "R12 done");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule